// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers level-sensitive interrupt requests in groups of 32, one group per bank, for a parameterised number of banks. Every request line is first passed through a two-flop synchroniser into the bus clock domain. The synchronised levels form a live, unlatched cause view. Nothing in the block stores a request edge, and software cannot clear a cause bit.

Each bank holds three independent enable masks over the same cause view. The normal mask drives the normal interrupt output. The fast mask drives the fast interrupt output. The endpoint mask drives the endpoint output. Each output exists once per bank and once more as an OR over all banks.

Software reaches the bank registers over a simple word-addressed read/write bus. Read data is registered, so it appears one cycle after the request. Choosing between pending sources and forming a vector is left to the consumer.

Top module: `lvl_intc`

## Requirements
- R1: After reset all three masks in every bank read as zero, every interrupt output is low and `bus_rdata` is zero.
- R2: A change on a source line reaches the cause view, and the outputs, after exactly two rising clock edges; a read sampled at the second edge still returns the old cause value.
- R3: Writes to a cause register (word offset 0) are ignored: the cause bit of an asserted source stays set and reads back as 1.
- R4: Each mask register (word offsets 1 normal, 2 fast, 3 endpoint) stores the full 32-bit write data and reads it back unchanged.
- R5: For bank n, `irq_bank[n]` is high exactly when some bit is set in both cause and the normal mask. `fast_bank[n]` and `ep_bank[n]` follow the same rule with their own masks, independently. A mask bit of 1 enables the source and 0 disables it.
- R6: `irq_any`, `fast_any` and `ep_any` are the OR of the corresponding per-bank outputs.
- R7: Writing zero to a bank's normal mask forces that bank's `irq_bank` bit low on the next cycle, whatever its inputs are, and leaves the fast and endpoint routes unchanged.
- R8: The word address is {bank, offset[1:0]}, so bank n starts at word 4n; source line 32n+k appears as cause bit k of bank n.
- R9: A read of a bank index at or above NUM_BANKS returns zero, and a write to it changes no register.
- R10: `bus_rdata` changes only in the cycle after a read request, and holds its value through idle cycles and writes.
- R11: The cause view is not latched: when a source line falls, its cause bit and the outputs it drives fall two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low reset |
| irq_src | input | NUM_BANKS*32 | Asynchronous level-sensitive request lines, line 32n+k belongs to bank n bit k |
| bus_sel | input | 1 | Register access request in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | BANK_BITS+2 | Word address {bank, offset} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_bank | output | NUM_BANKS | Per-bank normal interrupt |
| fast_bank | output | NUM_BANKS | Per-bank fast interrupt |
| ep_bank | output | NUM_BANKS | Per-bank endpoint interrupt |
| irq_any | output | 1 | Normal interrupt over all banks |
| fast_any | output | 1 | Fast interrupt over all banks |
| ep_any | output | 1 | Endpoint interrupt over all banks |

## Verification
The bench builds the block with NUM_BANKS set to 3. This gives a two-bit bank field with one unused bank index, 3, so reads and writes to an unmapped slot can be exercised against live neighbours. With three banks, one bank can be lit while the others stay quiet, which shows that the combined outputs gather every bank. It also shows that source 32n+k lands in bank n and no other.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

    localparam int LINES_PER_BANK = 32;
    localparam int SYNC_DEPTH     = 2;

    typedef enum logic [1:0] {
        OFS_CAUSE = 2'd0,
        OFS_NORM  = 2'd1,
        OFS_FAST  = 2'd2,
        OFS_EP    = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic [LINES_PER_BANK-1:0] norm_mask;
        logic [LINES_PER_BANK-1:0] fast_mask;
        logic [LINES_PER_BANK-1:0] ep_mask;
    } bank_regs_t;

    typedef struct packed {
        logic [LINES_PER_BANK-1:0] rdata;
    } top_regs_t;

endpackage

// File: rtl/lvl_intc_sync.sv
module lvl_intc_sync #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [DEPTH-1:0][WIDTH-1:0] chain_d;
    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[DEPTH-1];

endmodule

// File: rtl/lvl_intc_bank.sv
module lvl_intc_bank
    import lvl_intc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LINES_PER_BANK-1:0] src_i,
    input  logic                      wr_en,
    input  reg_ofs_e                  ofs_i,
    input  logic [LINES_PER_BANK-1:0] wdata_i,
    output logic [LINES_PER_BANK-1:0] rd_data_o,
    output logic [LINES_PER_BANK-1:0] cause_o,
    output logic                      norm_o,
    output logic                      fast_o,
    output logic                      ep_o
);

    bank_regs_t                st_d;
    bank_regs_t                st_q;
    logic [LINES_PER_BANK-1:0] cause;

    lvl_intc_sync #(
        .WIDTH (LINES_PER_BANK),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (src_i),
        .dout  (cause)
    );

    // Next-state: cause offset is read-only, masks take the full word.
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (ofs_i)
                OFS_NORM: st_d.norm_mask = wdata_i;
                OFS_FAST: st_d.fast_mask = wdata_i;
                OFS_EP:   st_d.ep_mask   = wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (ofs_i)
            OFS_CAUSE: rd_data_o = cause;
            OFS_NORM:  rd_data_o = st_q.norm_mask;
            OFS_FAST:  rd_data_o = st_q.fast_mask;
            default:   rd_data_o = st_q.ep_mask;
        endcase
    end

    assign cause_o = cause;
    assign norm_o  = |(cause & st_q.norm_mask);
    assign fast_o  = |(cause & st_q.fast_mask);
    assign ep_o    = |(cause & st_q.ep_mask);

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = BANK_BITS + 2,
    localparam int SRC_W     = NUM_BANKS * LINES_PER_BANK
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SRC_W-1:0]          irq_src,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [LINES_PER_BANK-1:0] bus_wdata,
    output logic [LINES_PER_BANK-1:0] bus_rdata,
    output logic [NUM_BANKS-1:0]      irq_bank,
    output logic [NUM_BANKS-1:0]      fast_bank,
    output logic [NUM_BANKS-1:0]      ep_bank,
    output logic                      irq_any,
    output logic                      fast_any,
    output logic                      ep_any
);

    logic [BANK_BITS-1:0]      bank_idx;
    reg_ofs_e                  ofs;
    logic [LINES_PER_BANK-1:0] bank_rd [NUM_BANKS];
    logic [SRC_W-1:0]          cause_all;
    top_regs_t                 top_d;
    top_regs_t                 top_q;

    assign bank_idx = bus_addr[ADDR_W-1:2];
    assign ofs      = reg_ofs_e'(bus_addr[1:0]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_en;
        assign wr_en = bus_sel && bus_wr && (bank_idx == BANK_BITS'(b));

        lvl_intc_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (irq_src[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .wr_en     (wr_en),
            .ofs_i     (ofs),
            .wdata_i   (bus_wdata),
            .rd_data_o (bank_rd[b]),
            .cause_o   (cause_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .norm_o    (irq_bank[b]),
            .fast_o    (fast_bank[b]),
            .ep_o      (ep_bank[b])
        );
    end

    // Read data: loaded only on a read; unmapped bank indices give zero.
    always_comb begin
        top_d = top_q;
        if (bus_sel && !bus_wr) begin
            top_d.rdata = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_idx == BANK_BITS'(b)) begin
                    top_d.rdata = bank_rd[b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata = top_q.rdata;
    assign irq_any   = |irq_bank;
    assign fast_any  = |fast_bank;
    assign ep_any    = |ep_bank;

endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk
    import lvl_intc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = BANK_BITS + 2,
    localparam int SRC_W     = NUM_BANKS * LINES_PER_BANK
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [SRC_W-1:0]          irq_src,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [LINES_PER_BANK-1:0] bus_wdata,
    input logic [LINES_PER_BANK-1:0] bus_rdata,
    input logic [NUM_BANKS-1:0]      irq_bank,
    input logic                      irq_any,
    input logic                      fast_any,
    input logic                      ep_any,
    input logic [SRC_W-1:0]          cause_all
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> (!irq_any && !fast_any && !ep_any && bus_rdata == '0));

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (cause_all == $past(irq_src, 2)));

    // R5
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_all == '0) |-> (!irq_any && !fast_any && !ep_any));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (int'(bus_addr[ADDR_W-1:2]) >= NUM_BANKS))
        |=> (bus_rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !(bus_sel && !bus_wr)) |=> $stable(bus_rdata));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_norm_off
        // R7
        norm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr == {BANK_BITS'(b), OFS_NORM}
             && bus_wdata == '0) |=> !irq_bank[b]);
    end

endmodule

bind lvl_intc lvl_intc_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_bank  (irq_bank),
    .irq_any   (irq_any),
    .fast_any  (fast_any),
    .ep_any    (ep_any),
    .cause_all (cause_all)
);

// File: tb/lvl_intc_bench.sv
`timescale 1ns/1ps
module lvl_intc_bench;

    localparam int NB  = 3;
    localparam int AW  = 4;
    localparam int SW  = NB * 32;
    localparam logic [1:0] O_CAUSE = 2'd0;
    localparam logic [1:0] O_NORM  = 2'd1;
    localparam logic [1:0] O_FAST  = 2'd2;
    localparam logic [1:0] O_EP    = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] irq_src = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NB-1:0] irq_bank, fast_bank, ep_bank;
    logic          irq_any, fast_any, ep_any;

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0] m_norm [NB];
    logic [31:0] m_fast [NB];
    logic [31:0] m_ep   [NB];

    always #5 clk = ~clk;

    lvl_intc #(.NUM_BANKS(NB)) u_lvl_intc (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_bank(irq_bank), .fast_bank(fast_bank), .ep_bank(ep_bank),
        .irq_any(irq_any), .fast_any(fast_any), .ep_any(ep_any)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int bank, input logic [1:0] ofs, input logic [31:0] data);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = {2'(bank), ofs}; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (bank < NB) begin
            if (ofs == O_NORM) m_norm[bank] = data;
            if (ofs == O_FAST) m_fast[bank] = data;
            if (ofs == O_EP)   m_ep[bank]   = data;
        end
    endtask

    task automatic rd(input int bank, input logic [1:0] ofs, output logic [31:0] data);
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = {2'(bank), ofs};
        @(negedge clk);
        bus_sel = 1'b0;
        data = bus_rdata;
    endtask

    task automatic set_src(input logic [SW-1:0] v);
        irq_src = v;
        repeat (2) @(negedge clk);
    endtask

    // Compare all outputs against the model built from masks and stable sources.
    task automatic chk_outputs(input string req);
        logic [NB-1:0] en, ef, ee;
        for (int b = 0; b < NB; b++) begin
            en[b] = |(irq_src[b*32 +: 32] & m_norm[b]);
            ef[b] = |(irq_src[b*32 +: 32] & m_fast[b]);
            ee[b] = |(irq_src[b*32 +: 32] & m_ep[b]);
        end
        chk({req, " irq_bank"},  32'(irq_bank),  32'(en));
        chk({req, " fast_bank"}, 32'(fast_bank), 32'(ef));
        chk({req, " ep_bank"},   32'(ep_bank),   32'(ee));
        chk({req, " any"}, {29'd0, irq_any, fast_any, ep_any}, {29'd0, |en, |ef, |ee});
    endtask

    task automatic clear_all();
        for (int b = 0; b < NB; b++) begin
            wr(b, O_NORM, 32'd0); wr(b, O_FAST, 32'd0); wr(b, O_EP, 32'd0);
        end
        set_src('0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rdata", bus_rdata, 32'd0);
        chk("R1 outputs", {irq_bank, fast_bank, ep_bank, irq_any, fast_any, ep_any}, 32'd0);
        for (int b = 0; b < NB; b++) begin
            rd(b, O_NORM, v); chk("R1 norm mask", v, 32'd0);
            rd(b, O_FAST, v); chk("R1 fast mask", v, 32'd0);
            rd(b, O_EP, v);   chk("R1 ep mask", v, 32'd0);
        end
    endtask

    task automatic t_mask_rw();
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            wr(b, O_NORM, 32'hA5A5_0000 | 32'(b));
            wr(b, O_FAST, 32'h0F0F_1000 | 32'(b));
            wr(b, O_EP,   32'hFFFF_FFF0 | 32'(b));
        end
        for (int b = 0; b < NB; b++) begin
            rd(b, O_NORM, v); chk("R4 R8 norm readback", v, 32'hA5A5_0000 | 32'(b));
            rd(b, O_FAST, v); chk("R4 R8 fast readback", v, 32'h0F0F_1000 | 32'(b));
            rd(b, O_EP, v);   chk("R4 R8 ep readback", v, 32'hFFFF_FFF0 | 32'(b));
        end
        clear_all();
    endtask

    task automatic t_sync();
        logic [31:0] v;
        wr(0, O_NORM, 32'h0000_0020);
        irq_src[5] = 1'b1;
        @(negedge clk);
        chk("R2 irq after one edge", 32'(irq_bank[0]), 32'd0);
        rd(0, O_CAUSE, v);
        chk("R2 cause read at second edge", v, 32'd0);
        chk("R2 irq after two edges", 32'(irq_bank[0]), 32'd1);
        rd(0, O_CAUSE, v);
        chk("R2 cause settled", v, 32'h0000_0020);
        irq_src[5] = 1'b0;
        @(negedge clk);
        chk("R11 irq one edge after fall", 32'(irq_bank[0]), 32'd1);
        @(negedge clk);
        chk("R11 irq two edges after fall", 32'(irq_bank[0]), 32'd0);
        clear_all();
    endtask

    task automatic t_cause_ro();
        logic [31:0] v;
        set_src(SW'(32'h0000_8001));
        wr(0, O_CAUSE, 32'd0);
        rd(0, O_CAUSE, v);
        chk("R3 cause after write zero", v, 32'h0000_8001);
        wr(0, O_CAUSE, 32'hFFFF_FFFF);
        rd(0, O_CAUSE, v);
        chk("R3 cause after write ones", v, 32'h0000_8001);
        clear_all();
    endtask

    task automatic t_routes();
        wr(0, O_NORM, 32'h0000_00F0);
        wr(0, O_FAST, 32'h0000_0F00);
        wr(0, O_EP,   32'h0000_F000);
        set_src(SW'(32'h0000_0010));
        chk_outputs("R5 norm only");
        set_src(SW'(32'h0000_0100));
        chk_outputs("R5 fast only");
        set_src(SW'(32'h0000_1000));
        chk_outputs("R5 ep only");
        set_src(SW'(32'h0000_1110));
        chk_outputs("R5 all routes");
        set_src(SW'(32'h0001_0001));
        chk_outputs("R5 unmasked sources");
        clear_all();
    endtask

    task automatic t_combined();
        wr(2, O_NORM, 32'h8000_0000);
        wr(2, O_EP,   32'h8000_0000);
        set_src({32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
        chk_outputs("R6 bank2 only");
        chk("R6 irq_bank vector", 32'(irq_bank), 32'h4);
        chk("R6 irq_any", 32'(irq_any), 32'd1);
        chk("R6 fast_any", 32'(fast_any), 32'd0);
        clear_all();
    endtask

    task automatic t_irq_zero();
        wr(1, O_NORM, 32'hFFFF_FFFF);
        wr(1, O_FAST, 32'hFFFF_FFFF);
        set_src({32'd0, 32'h1234_5678, 32'd0});
        chk("R7 irq before", 32'(irq_bank[1]), 32'd1);
        wr(1, O_NORM, 32'd0);
        chk("R7 irq after zero", 32'(irq_bank[1]), 32'd0);
        chk("R7 fast untouched", 32'(fast_bank[1]), 32'd1);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(0, O_NORM, 32'h1111_1111);
        wr(1, O_FAST, 32'h2222_2222);
        wr(2, O_EP,   32'h3333_3333);
        for (int o = 0; o < 4; o++) wr(3, 2'(o), 32'hDEAD_BEEF);
        for (int o = 0; o < 4; o++) begin
            rd(3, 2'(o), v); chk("R9 unmapped read", v, 32'd0);
        end
        rd(0, O_NORM, v); chk("R9 bank0 kept", v, 32'h1111_1111);
        rd(1, O_FAST, v); chk("R9 bank1 kept", v, 32'h2222_2222);
        rd(2, O_EP, v);   chk("R9 bank2 kept", v, 32'h3333_3333);
        rd(0, O_FAST, v); chk("R9 bank0 fast kept", v, 32'd0);
        clear_all();
    endtask

    task automatic t_bank_map();
        logic [31:0] v;
        logic [SW-1:0] s;
        s = '0;
        s[32*1 + 7] = 1'b1;
        set_src(s);
        rd(1, O_CAUSE, v); chk("R8 bank1 cause", v, 32'h0000_0080);
        rd(0, O_CAUSE, v); chk("R8 bank0 cause", v, 32'd0);
        rd(2, O_CAUSE, v); chk("R8 bank2 cause", v, 32'd0);
        clear_all();
    endtask

    task automatic t_rdata_hold();
        logic [31:0] v;
        wr(2, O_FAST, 32'hCAFE_0042);
        rd(2, O_FAST, v);
        repeat (3) @(negedge clk);
        chk("R10 hold idle", bus_rdata, 32'hCAFE_0042);
        wr(2, O_FAST, 32'h0000_0001);
        chk("R10 hold across write", bus_rdata, 32'hCAFE_0042);
        rd(2, O_FAST, v);
        chk("R10 updates on read", v, 32'h0000_0001);
        clear_all();
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_norm[b] = '0; m_fast[b] = '0; m_ep[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_sync();
        t_cause_ro();
        t_routes();
        t_combined();
        t_irq_zero();
        t_unmapped();
        t_bank_map();
        t_rdata_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule